// File: doc/BRIEF.md
# Power-Mode-Aware Single-Port SRAM

This block is a synthesizable single-port memory that models the digital side of three low-power modes. A power controller drives three separate mode inputs. In light sleep the array keeps its contents and the read port freezes. In deep sleep the periphery is off: the contents are kept and the read port is clamped low. In shutdown the array loses power: the read port is clamped low and the contents become a known poison pattern that stands for "unknown".

On every clock edge a small state machine settles the memory into one of five states. The states are `ST_ACTIVE`, `ST_LIGHT`, `ST_DEEP`, `ST_SHUT` and `ST_WAKE`. Its transitions are:

- enter: `ST_ACTIVE` or `ST_WAKE` to a sleep state when any mode input is high.
- deepen: `ST_LIGHT` to `ST_DEEP` or `ST_SHUT`, and `ST_DEEP` to `ST_SHUT`.
- exit: a sleep state to `ST_WAKE` when all mode inputs are low. This loads the latency of the mode being left.
- count: `ST_WAKE` stays in `ST_WAKE` while the count is above one.
- resume: `ST_WAKE` to `ST_ACTIVE` when the count runs out.

The ready output is high only in `ST_ACTIVE`. A controller uses it to know when accesses may be issued again.

Top module: `pm_sram`

## Requirements
- R1: After reset, ready_o is 1, err_o is 0, rdata_o is 0 and every word of the array reads as 0.
- R2: In the ready state with no mode input high, an access with ce_i=1 is performed. A write (we_i=1) stores wdata_i at addr_i on the clock edge and leaves rdata_o unchanged. A read (we_i=0) places the word at addr_i on rdata_o after that same edge.
- R3: When several mode inputs are high together, the deepest one is taken. The order from deepest is sd_i, then ds_i, then ls_i.
- R4: In light sleep the array contents are kept and rdata_o holds its last value.
- R5: From the edge that enters deep sleep, rdata_o is 0. It stays 0, through wake-up, until the next performed read. The array contents are kept.
- R6: Entering shutdown clamps rdata_o to 0 in the same way. It also replaces every word with the poison pattern, in which bit i is 1 exactly when i is odd (0xAAAA for 16 bits).
- R7: ready_o is 0 after any clock edge at which a mode input was sampled high.
- R8: After the edge that samples all mode inputs low in a sleep state, ready_o rises exactly WAKE_LS, WAKE_DS or WAKE_SD edges later. The latency used is that of the sleep state being left.
- R9: A sleep state only deepens. While asleep, a request for a lighter mode than the current one leaves the mode, the output behaviour and the later wake latency unchanged.
- R10: An access (ce_i=1) at an edge where ready_o is 0 or any mode input is high is ignored. The array and rdata_o are untouched, and err_o is set.
- R11: err_o stays 1 until reset once it is set.
- R12: A mode input raised during wake-up returns the memory to the requested sleep state. The next exit uses the latency of that new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| ls_i | input | 1 | Light-sleep request |
| ds_i | input | 1 | Deep-sleep request |
| sd_i | input | 1 | Shutdown request |
| ready_o | output | 1 | Access allowed (awake and wake-up complete) |
| err_o | output | 1 | Sticky flag for an ignored access |

## Verification
The bench measures the wake latency of each mode, and also the latency after a lighter request made while in a deeper mode. A design that counted from the wrong mode, or let a lighter request take over, would raise ready one or several cycles early. This would let the controller access a memory that is still asleep. After a shutdown it reads back the poison pattern, and after a deep sleep it reads back the retained data. A design that mixed up retention between the two modes would return stale or corrupted words. It issues writes in light sleep, during wake-up and in the same cycle as a sleep request. A design that let any of them through would alter the array, and a later read would show it. It also checks that the error flag is set by these writes and never clears.

// File: rtl/pm_sram_pkg.sv
`timescale 1ns/1ps
package pm_sram_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE = 3'd0,
        ST_LIGHT  = 3'd1,
        ST_DEEP   = 3'd2,
        ST_SHUT   = 3'd3,
        ST_WAKE   = 3'd4
    } pm_state_t;

    // ordered so that a larger value is a deeper request
    typedef enum logic [1:0] {
        LVL_NONE  = 2'd0,
        LVL_LIGHT = 2'd1,
        LVL_DEEP  = 2'd2,
        LVL_SHUT  = 2'd3
    } pm_level_t;

endpackage

// File: rtl/pm_sram_prio.sv
`timescale 1ns/1ps
module pm_sram_prio
    import pm_sram_pkg::*;
(
    input  logic      ls_i,
    input  logic      ds_i,
    input  logic      sd_i,
    output pm_level_t lvl_o
);

    // deepest requested mode wins (R3)
    always_comb begin
        if (sd_i)      lvl_o = LVL_SHUT;
        else if (ds_i) lvl_o = LVL_DEEP;
        else if (ls_i) lvl_o = LVL_LIGHT;
        else           lvl_o = LVL_NONE;
    end

endmodule

// File: rtl/pm_sram_ctrl.sv
`timescale 1ns/1ps
module pm_sram_ctrl
    import pm_sram_pkg::*;
#(
    parameter int WAKE_LS = 1,
    parameter int WAKE_DS = 3,
    parameter int WAKE_SD = 6
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  pm_level_t req_i,
    output logic      ready_o,
    output logic      grant_o,
    output logic      clr_rd_o,
    output logic      poison_o
);

    localparam int MAX_A = (WAKE_LS > WAKE_DS) ? WAKE_LS : WAKE_DS;
    localparam int MAX_L = (MAX_A > WAKE_SD) ? MAX_A : WAKE_SD;
    localparam int CW    = $clog2(MAX_L + 1);

    pm_state_t         state_q, state_d;
    logic [CW-1:0]     cnt_q, cnt_d;

    function automatic pm_state_t sleep_of(pm_level_t l);
        unique case (l)
            LVL_SHUT:  return ST_SHUT;
            LVL_DEEP:  return ST_DEEP;
            default:   return ST_LIGHT;
        endcase
    endfunction

    function automatic logic [CW-1:0] lat_of(pm_state_t s);
        unique case (s)
            ST_SHUT:  return CW'(WAKE_SD);
            ST_DEEP:  return CW'(WAKE_DS);
            default:  return CW'(WAKE_LS);
        endcase
    endfunction

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (req_i != LVL_NONE) state_d = sleep_of(req_i);      // enter
            end
            ST_LIGHT, ST_DEEP, ST_SHUT: begin
                if (req_i == LVL_NONE) begin                           // exit
                    state_d = ST_WAKE;
                    cnt_d   = lat_of(state_q);
                end else if (sleep_of(req_i) > state_q) begin          // deepen
                    state_d = sleep_of(req_i);
                end
            end
            ST_WAKE: begin
                if (req_i != LVL_NONE) begin                           // enter
                    state_d = sleep_of(req_i);
                end else if (cnt_q <= CW'(1)) begin                    // resume
                    state_d = ST_ACTIVE;
                end else begin                                         // count
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_ACTIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        ready_o  = (state_q == ST_ACTIVE);
        grant_o  = (state_q == ST_ACTIVE) && (req_i == LVL_NONE);
        clr_rd_o = ((state_d == ST_DEEP) || (state_d == ST_SHUT)) &&
                   !((state_q == ST_DEEP) || (state_q == ST_SHUT));
        poison_o = (state_d == ST_SHUT) && (state_q != ST_SHUT);
    end

endmodule

// File: rtl/pm_sram_array.sv
`timescale 1ns/1ps
module pm_sram_array #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              poison_i,
    input  logic              clr_rd_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int                DEPTH  = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] POISON = {(DATA_W/2){2'b10}};

    logic [DATA_W-1:0] row_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
                word_q <= '0;
            else if (poison_i)
                word_q <= POISON;
            else if (wr_i && (addr_i == ADDR_W'(g)))
                word_q <= wdata_i;
        end
        assign row_q[g] = word_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            rdata_o <= '0;
        else if (clr_rd_i)
            rdata_o <= '0;
        else if (rd_i)
            rdata_o <= row_q[addr_i];
    end

endmodule

// File: rtl/pm_sram.sv
`timescale 1ns/1ps
module pm_sram
    import pm_sram_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int WAKE_LS = 1,
    parameter int WAKE_DS = 3,
    parameter int WAKE_SD = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ce_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              ls_i,
    input  logic              ds_i,
    input  logic              sd_i,
    output logic              ready_o,
    output logic              err_o
);

    pm_level_t req;
    logic      grant, clr_rd, poison;
    logic      err_q;

    pm_sram_prio u_prio (
        .ls_i  (ls_i),
        .ds_i  (ds_i),
        .sd_i  (sd_i),
        .lvl_o (req)
    );

    pm_sram_ctrl #(
        .WAKE_LS (WAKE_LS),
        .WAKE_DS (WAKE_DS),
        .WAKE_SD (WAKE_SD)
    ) u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (req),
        .ready_o  (ready_o),
        .grant_o  (grant),
        .clr_rd_o (clr_rd),
        .poison_o (poison)
    );

    pm_sram_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (ce_i && we_i && grant),
        .rd_i     (ce_i && !we_i && grant),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .poison_i (poison),
        .clr_rd_i (clr_rd),
        .rdata_o  (rdata_o)
    );

    // sticky flag for a refused access (R10, R11)
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            err_q <= 1'b0;
        else if (ce_i && !grant)
            err_q <= 1'b1;
    end

    assign err_o = err_q;

endmodule

// File: rtl/pm_sram_chk.sv
`timescale 1ns/1ps
module pm_sram_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              ce_i,
    input logic              ls_i,
    input logic              ds_i,
    input logic              sd_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              ready_o,
    input logic              err_o
);

    logic any_req;
    assign any_req = ls_i || ds_i || sd_i;

    assert_sleep_drops_ready_R7: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        any_req |=> !ready_o);

    // covers R6 as well: shutdown clamps exactly like deep sleep
    assert_deep_clamp_R5: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        (ds_i || sd_i) |=> (rdata_o == '0));

    assert_light_hold_R4: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        (ls_i && !ds_i && !sd_i) |=> $stable(rdata_o));

    assert_refused_flags_R10: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        (ce_i && (!ready_o || any_req)) |=> err_o);

    assert_err_sticky_R11: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o);

    assert_wake_quiet_R8: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        $rose(ready_o) |-> $past(!any_req));

endmodule

bind pm_sram pm_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_i    (ce_i),
    .ls_i    (ls_i),
    .ds_i    (ds_i),
    .sd_i    (sd_i),
    .rdata_o (rdata_o),
    .ready_o (ready_o),
    .err_o   (err_o)
);

// File: tb/pm_sram_bench.sv
`timescale 1ns/1ps
module pm_sram_bench;

    localparam int AW = 5;
    localparam int DW = 16;
    localparam int LS_LAT = 1;
    localparam int DS_LAT = 3;
    localparam int SD_LAT = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce = 1'b0, we = 1'b0, ls = 1'b0, ds = 1'b0, sd = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wd = '0;
    logic [DW-1:0] rdata;
    logic          ready, err;

    int    total = 0;
    int    bad = 0;
    string tag = "R1";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    pm_sram #(.ADDR_W(AW), .DATA_W(DW), .WAKE_LS(LS_LAT),
              .WAKE_DS(DS_LAT), .WAKE_SD(SD_LAT)) u_pm_sram (
        .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .we_i(we), .addr_i(addr),
        .wdata_i(wd), .rdata_o(rdata), .ls_i(ls), .ds_i(ds), .sd_i(sd),
        .ready_o(ready), .err_o(err));

    // ---------------- behavioural reference model ----------------
    logic [DW-1:0] m_mem [1<<AW];
    logic [DW-1:0] m_rd;
    int            m_lvl;   // 0 awake, 1 light, 2 deep, 3 shut
    int            m_wake;  // cycles of wake-up left
    bit            m_err;

    function automatic logic [DW-1:0] poison_word();
        logic [DW-1:0] p;
        for (int i = 0; i < DW; i++) p[i] = (i % 2 == 1);
        return p;
    endfunction

    function automatic int lat(int l);
        if (l == 3) return SD_LAT;
        if (l == 2) return DS_LAT;
        return LS_LAT;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1<<AW); i++) m_mem[i] = '0;
            m_rd = '0; m_lvl = 0; m_wake = 0; m_err = 0;
        end else begin
            int  rq;
            bit  ok;
            rq = sd ? 3 : ds ? 2 : ls ? 1 : 0;
            ok = (m_lvl == 0) && (m_wake == 0) && (rq == 0);
            if (ce && !ok) m_err = 1;
            if (ce && ok) begin
                if (we) m_mem[addr] = wd;
                else    m_rd = m_mem[addr];
            end
            if (m_lvl != 0) begin
                if (rq == 0) begin
                    m_wake = lat(m_lvl);
                    m_lvl  = 0;
                end else if (rq > m_lvl) begin
                    if (m_lvl < 2) m_rd = '0;
                    if (rq == 3) for (int i = 0; i < (1<<AW); i++) m_mem[i] = poison_word();
                    m_lvl = rq;
                end
            end else if (rq != 0) begin
                if (rq >= 2) m_rd = '0;
                if (rq == 3) for (int i = 0; i < (1<<AW); i++) m_mem[i] = poison_word();
                m_lvl = rq; m_wake = 0;
            end else if (m_wake > 0) begin
                m_wake = m_wake - 1;
            end
        end
    end

    task automatic chk(string t, logic [31:0] act, logic [31:0] exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tag, 32'(rdata), 32'(m_rd), "rdata");
            chk(tag, 32'(ready), 32'((m_lvl == 0) && (m_wake == 0)), "ready");
            chk(tag, 32'(err), 32'(m_err), "err");
        end
    end

    task automatic cyc(bit c, bit w, int a, logic [DW-1:0] d, bit l, bit p, bit s);
        @(negedge clk);
        ce = c; we = w; addr = AW'(a); wd = d; ls = l; ds = p; sd = s;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, 0, 0, 0);
    endtask

    // inputs already dropped; count negedges until ready is seen
    task automatic wake_len(string t, int exp_lat);
        int k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!ready && k < 50);
        chk(t, 32'(k), 32'(exp_lat + 1), "wake latency");
    endtask

    task automatic rd_expect(string t, int a, logic [DW-1:0] exp);
        cyc(1, 0, a, '0, 0, 0, 0);
        idle(1);
        chk(t, 32'(rdata), 32'(exp), "read value");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired in %s", tag);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        tag = "R1";
        chk("R1", 32'(ready), 1, "ready after reset");
        chk("R1", 32'(err), 0, "err after reset");
        chk("R1", 32'(rdata), 0, "rdata after reset");
        rd_expect("R1", 7, '0);

        // R2 writes and reads
        tag = "R2";
        for (int i = 0; i < 8; i++) cyc(1, 1, i, DW'(16'h1000 + i * 16'h0111), 0, 0, 0);
        rd_expect("R2", 5, 16'h1555);
        cyc(1, 1, 6, 16'h7777, 0, 0, 0);
        idle(1);
        chk("R2", 32'(rdata), 32'h1555, "write leaves rdata");
        rd_expect("R2", 6, 16'h7777);

        // R4 light sleep holds output and contents, R7 ready drops
        tag = "R4";
        rd_expect("R4", 2, 16'h1222);
        cyc(0, 0, 0, '0, 1, 0, 0);
        idle(0);
        cyc(0, 0, 0, '0, 1, 0, 0);
        chk("R7", 32'(ready), 0, "ready in light sleep");
        repeat (3) cyc(0, 0, 0, '0, 1, 0, 0);
        chk("R4", 32'(rdata), 32'h1222, "light holds rdata");
        cyc(0, 0, 0, '0, 0, 0, 0);
        tag = "R8";
        wake_len("R8", LS_LAT);
        rd_expect("R4", 3, 16'h1333);

        // R5 deep sleep clamps output, keeps contents
        tag = "R5";
        repeat (4) cyc(0, 0, 0, '0, 0, 1, 0);
        idle(0);
        cyc(0, 0, 0, '0, 0, 1, 0);
        chk("R5", 32'(rdata), 0, "deep clamps rdata");
        cyc(0, 0, 0, '0, 0, 0, 0);
        wake_len("R8", DS_LAT);
        chk("R5", 32'(rdata), 0, "rdata zero until read");
        rd_expect("R5", 2, 16'h1222);

        // R3 light+deep gives deep
        tag = "R3";
        rd_expect("R3", 4, 16'h1444);
        repeat (3) cyc(0, 0, 0, '0, 1, 1, 0);
        chk("R3", 32'(rdata), 0, "light+deep clamps");
        cyc(0, 0, 0, '0, 0, 0, 0);
        wake_len("R3", DS_LAT);
        rd_expect("R3", 4, 16'h1444);

        // R3/R6 all three together gives shutdown with poison
        tag = "R6";
        repeat (3) cyc(0, 0, 0, '0, 1, 1, 1);
        chk("R6", 32'(rdata), 0, "shut clamps");
        cyc(0, 0, 0, '0, 0, 0, 0);
        wake_len("R3", SD_LAT);
        rd_expect("R6", 4, poison_word());
        rd_expect("R6", 31, poison_word());

        // R9 lighter request while deep does not shorten wake-up
        tag = "R9";
        cyc(1, 1, 9, 16'h5A5A, 0, 0, 0);
        rd_expect("R9", 9, 16'h5A5A);
        repeat (2) cyc(0, 0, 0, '0, 0, 1, 0);
        repeat (3) cyc(0, 0, 0, '0, 1, 0, 0);
        chk("R9", 32'(rdata), 0, "still clamped");
        cyc(0, 0, 0, '0, 0, 0, 0);
        wake_len("R9", DS_LAT);
        rd_expect("R9", 9, 16'h5A5A);

        // R12 request during wake-up
        tag = "R12";
        repeat (3) cyc(0, 0, 0, '0, 0, 1, 0);
        idle(2);
        repeat (2) cyc(0, 0, 0, '0, 1, 0, 0);
        chk("R12", 32'(ready), 0, "back asleep");
        cyc(0, 0, 0, '0, 0, 0, 0);
        wake_len("R12", LS_LAT);

        // R10 refused accesses, R11 sticky flag
        tag = "R10";
        chk("R10", 32'(err), 0, "no error yet");
        cyc(1, 1, 9, 16'hBEEF, 1, 0, 0);
        cyc(0, 0, 0, '0, 1, 0, 0);
        chk("R10", 32'(err), 1, "err after asleep write");
        cyc(0, 0, 0, '0, 0, 0, 0);
        cyc(1, 0, 9, '0, 0, 0, 0);
        cyc(0, 0, 0, '0, 0, 0, 0);
        rd_expect("R10", 9, 16'h5A5A);
        repeat (2) cyc(0, 0, 0, '0, 0, 1, 0);
        cyc(0, 0, 0, '0, 0, 0, 0);
        cyc(1, 1, 9, 16'hDEAD, 0, 0, 0);
        idle(DS_LAT + 1);
        rd_expect("R10", 9, 16'h5A5A);
        tag = "R11";
        idle(10);
        chk("R11", 32'(err), 1, "err still set");

        // reset clears everything again (R1)
        tag = "R1";
        done = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        done = 1'b0;
        idle(1);
        chk("R1", 32'(err), 0, "err cleared by reset");
        rd_expect("R1", 9, '0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule